// File: doc/BRIEF.md
# Burst Transmit Interface Sequencer

This block runs in the master-clock domain of a burst modulator and handles the timing around a transmit burst. Once the power enable is seen high, it waits out a fixed calibration interval. It then raises a ready flag and waits for a burst request. When a burst starts, it generates a slow bit clock that a host uses to shift serial data in. It captures one data bit on each falling edge of that clock and packs the bits into dibits.

When the burst request drops, the block finishes the dibit in progress. It then keeps clocking for a fixed number of further symbols, which flushes the downstream pulse-shaping filter, and returns to ready. It also issues one-cycle ramp-up and ramp-down triggers and a delayed copy of the burst request that can switch a power amplifier in step with the output pipeline. Driving the power enable low puts the block to sleep: every counter clears and every output goes idle. The calibration itself is not modelled; the block only counts out its length.

Top module: `burst_tx_seq`

## Requirements
- R1: While rst_ni is low, and after reset while power_i stays low, ready_o, txclk_o, bout_o, bit_valid_o, dibit_valid_o, ramp_up_o and ramp_down_o are all 0.
- R2: ready_o rises CAL_CYCLES rising edges after the edge that first samples power_i high.
- R3: In ready, a rising burst_i sampled at an edge clears ready_o at that same edge.
- R4: A burst_i rise sampled while ready_o is low is ignored. A burst_i level that is already high when ready_o rises does not start a burst. In both cases ready_o stays high and txclk_o stays low.
- R5: txclk_o first goes high START_DLY edges after the edge that cleared ready_o.
- R6: In a burst, txclk_o is periodic, high for HALF_PER clocks and then low for HALF_PER clocks.
- R7: At each falling edge of txclk_o, bit_o takes txdata_i, and bit_valid_o is 1 for exactly that one clock cycle.
- R8: Bits pair into dibits. The first bit of a pair goes to dibit_o[1] and the second to dibit_o[0]. dibit_valid_o pulses together with bit_valid_o on every second bit of a burst.
- R9: After burst_i falls, the dibit being received is completed, and then 2*FLUSH_SYM more bits are clocked in. ready_o rises at the same edge as the last txclk_o fall, and ready_o and txclk_o are never high together.
- R10: ramp_up_o pulses for one cycle as ready_o falls at burst start. ramp_down_o pulses for one cycle at the fall that completes the last dibit before the flush.
- R11: bout_o takes a new level of burst_i BOUT_DLY-1 edges after the edge that first samples it, provided level changes are at least BOUT_DLY clocks apart.
- R12: One edge after power_i is sampled low, ready_o, txclk_o and bout_o are 0, and no bit strobe follows until the block is powered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| power_i | input | 1 | Power enable; low means sleep |
| burst_i | input | 1 | Burst request |
| txdata_i | input | 1 | Serial transmit data from the host |
| ready_o | output | 1 | Calibrated and idle, able to accept a burst |
| txclk_o | output | 1 | Bit clock to the host |
| bit_valid_o | output | 1 | One-cycle strobe for a captured bit |
| bit_o | output | 1 | Last captured bit |
| dibit_valid_o | output | 1 | One-cycle strobe for a completed dibit |
| dibit_o | output | 2 | Completed dibit, first bit in the MSB |
| ramp_up_o | output | 1 | Ramp-up trigger pulse |
| ramp_down_o | output | 1 | Ramp-down trigger pulse |
| bout_o | output | 1 | Burst request delayed by BOUT_DLY clocks |

## Verification
Bursts are run with the stop point placed so that the request drops during an odd-numbered bit and during an even-numbered bit. This separates the case where the half-finished dibit must be completed first from the case where it is already complete, and in each case the total bit count and the ramp-down position are checked. Directed cases stop on the very first bit, hold the request high across the flush, raise it during calibration, and cut power in the middle of a burst. These show that the start logic works on edges rather than levels and that sleep clears everything. Random data bits show whether the dibit keeps the bit order, and the delayed burst-out is timed on every level change.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP,
    ST_CAL,
    ST_READY,
    ST_RUN,
    ST_FLUSH
  } seq_state_e;
endpackage

// File: rtl/bseq_cal_timer.sv
module bseq_cal_timer #(
  parameter int CAL_CYCLES = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(CAL_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == CNT_W'(CAL_CYCLES - 1));
endmodule

// File: rtl/bseq_bitclk.sv
module bseq_bitclk #(
  parameter int HALF_PER  = 32,
  parameter int START_DLY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic txclk_o,
  output logic fall_o
);
  localparam int PERIOD = 2 * HALF_PER;
  localparam int PH_W   = $clog2(PERIOD);
  localparam int LD_W   = $clog2(START_DLY + 1);

  logic            active_q;
  logic [LD_W-1:0] lead_q;
  logic [PH_W-1:0] ph_q, ph_nxt;
  logic            txclk_q;

  assign ph_nxt = (ph_q == PH_W'(PERIOD - 1)) ? '0 : ph_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      lead_q   <= '0;
      ph_q     <= '0;
      txclk_q  <= 1'b0;
    end else if (!en_i) begin
      active_q <= 1'b0;
      lead_q   <= '0;
      ph_q     <= '0;
      txclk_q  <= 1'b0;
    end else if (!active_q) begin
      if (lead_q == LD_W'(START_DLY - 1)) begin
        active_q <= 1'b1;
        txclk_q  <= 1'b1;
        ph_q     <= '0;
      end else begin
        lead_q <= lead_q + 1'b1;
      end
    end else begin
      ph_q    <= ph_nxt;
      txclk_q <= (ph_nxt < PH_W'(HALF_PER));
    end
  end

  assign txclk_o = txclk_q;
  assign fall_o  = en_i && active_q && (ph_q == PH_W'(HALF_PER - 1));

  // R6
  txclk_high_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $rose(txclk_o)) |=> (txclk_o || !en_i || !$past(en_i)));
endmodule

// File: rtl/bseq_deser.sv
module bseq_deser (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       fall_i,
  input  logic       txdata_i,
  output logic       pair_done_o,
  output logic       bit_valid_o,
  output logic       bit_o,
  output logic       dibit_valid_o,
  output logic [1:0] dibit_o
);
  logic       half_q, first_q;
  logic       bv_q, bit_q, dv_q;
  logic [1:0] dibit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q  <= 1'b0;
      first_q <= 1'b0;
      bv_q    <= 1'b0;
      bit_q   <= 1'b0;
      dv_q    <= 1'b0;
      dibit_q <= '0;
    end else if (!en_i) begin
      half_q <= 1'b0;
      bv_q   <= 1'b0;
      dv_q   <= 1'b0;
    end else begin
      bv_q <= fall_i;
      dv_q <= fall_i && half_q;
      if (fall_i) begin
        bit_q  <= txdata_i;
        half_q <= ~half_q;
        if (!half_q) first_q <= txdata_i;
        else         dibit_q <= {first_q, txdata_i};
      end
    end
  end

  assign pair_done_o   = en_i && fall_i && half_q;
  assign bit_valid_o   = bv_q;
  assign bit_o         = bit_q;
  assign dibit_valid_o = dv_q;
  assign dibit_o       = dibit_q;

  // R8
  dibit_with_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dibit_valid_o |-> bit_valid_o);
endmodule

// File: rtl/bseq_bout_delay.sv
module bseq_bout_delay #(
  parameter int BOUT_DLY = 480
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic burst_i,
  output logic bout_o
);
  localparam int CNT_W = $clog2(BOUT_DLY + 1);

  logic             pend_q, bout_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      bout_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!en_i) begin
      pend_q <= 1'b0;
      bout_q <= 1'b0;
      cnt_q  <= '0;
    end else if (burst_i != pend_q) begin
      // one pending edge; a newer edge restarts the count
      pend_q <= burst_i;
      if (BOUT_DLY == 1) bout_q <= burst_i;
      else               cnt_q  <= CNT_W'(BOUT_DLY - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) bout_q <= pend_q;
    end
  end

  assign bout_o = bout_q;
endmodule

// File: rtl/burst_tx_seq.sv
module burst_tx_seq
  import burst_seq_pkg::*;
#(
  parameter int CAL_CYCLES = 4096,
  parameter int START_DLY  = 2,
  parameter int HALF_PER   = 32,
  parameter int FLUSH_SYM  = 4,
  parameter int BOUT_DLY   = 480
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       power_i,
  input  logic       burst_i,
  input  logic       txdata_i,
  output logic       ready_o,
  output logic       txclk_o,
  output logic       bit_valid_o,
  output logic       bit_o,
  output logic       dibit_valid_o,
  output logic [1:0] dibit_o,
  output logic       ramp_up_o,
  output logic       ramp_down_o,
  output logic       bout_o
);
  localparam int FLUSH_BITS = 2 * FLUSH_SYM;
  localparam int FL_W       = $clog2(FLUSH_BITS + 1);

  seq_state_e      state_q, state_d;
  logic            burst_q, end_req_q;
  logic [FL_W-1:0] flush_q;
  logic            ramp_up_q, ramp_down_q;
  logic            start, stopping, cal_done, fall, pair_done;
  logic            clk_en, awake;

  assign awake    = power_i && (state_q != ST_SLEEP);
  assign clk_en   = power_i && ((state_q == ST_RUN) || (state_q == ST_FLUSH));
  assign start    = (state_q == ST_READY) && burst_i && !burst_q;
  assign stopping = (state_q == ST_RUN) && pair_done && (end_req_q || !burst_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_SLEEP: if (power_i)  state_d = ST_CAL;
      ST_CAL:   if (cal_done) state_d = ST_READY;
      ST_READY: if (start)    state_d = ST_RUN;
      ST_RUN:   if (stopping) state_d = ST_FLUSH;
      ST_FLUSH: if (fall && flush_q == FL_W'(1)) state_d = ST_READY;
      default:  state_d = ST_SLEEP;
    endcase
    if (!power_i) state_d = ST_SLEEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_SLEEP;
      burst_q     <= 1'b0;
      end_req_q   <= 1'b0;
      flush_q     <= '0;
      ramp_up_q   <= 1'b0;
      ramp_down_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      burst_q     <= burst_i;
      end_req_q   <= (state_q == ST_RUN) && (end_req_q || !burst_i);
      ramp_up_q   <= start && power_i;
      ramp_down_q <= stopping && power_i;
      if (stopping)
        flush_q <= FL_W'(FLUSH_BITS);
      else if (state_q == ST_FLUSH && fall)
        flush_q <= flush_q - 1'b1;
    end
  end

  bseq_cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (power_i && state_q == ST_CAL),
    .done_o (cal_done)
  );

  bseq_bitclk #(.HALF_PER(HALF_PER), .START_DLY(START_DLY)) u_bitclk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (clk_en),
    .txclk_o (txclk_o),
    .fall_o  (fall)
  );

  bseq_deser u_deser (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (clk_en),
    .fall_i        (fall),
    .txdata_i      (txdata_i),
    .pair_done_o   (pair_done),
    .bit_valid_o   (bit_valid_o),
    .bit_o         (bit_o),
    .dibit_valid_o (dibit_valid_o),
    .dibit_o       (dibit_o)
  );

  bseq_bout_delay #(.BOUT_DLY(BOUT_DLY)) u_bout (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (awake),
    .burst_i (burst_i),
    .bout_o  (bout_o)
  );

  assign ready_o     = (state_q == ST_READY);
  assign ramp_up_o   = ramp_up_q;
  assign ramp_down_o = ramp_down_q;

  // R3
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && power_i && $rose(burst_i)) |=> !ready_o);

  // R4
  early_burst_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && $rose(burst_i)) |=> !ramp_up_o);

  // R7
  bit_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> $fell(txclk_o));

  // R9
  ready_txclk_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && txclk_o));

  // R10
  ramp_up_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_up_o |-> (!ready_o && $past(ready_o)));

  // R12
  sleep_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !power_i |=> (!ready_o && !txclk_o && !bout_o));
endmodule

// File: tb/burst_tx_seq_bench.sv
module burst_tx_seq_bench;
  localparam int CAL   = 4096;
  localparam int SD    = 2;
  localparam int HALF  = 32;
  localparam int FLUSH = 4;
  localparam int BD    = 480;

  logic       clk = 1'b0;
  logic       rst_n, power, burst, txdata;
  logic       ready, txclk, bit_valid, bit_v, dibit_valid, ramp_up, ramp_down, bout;
  logic [1:0] dibit;

  int nvec = 0, nerr = 0;
  int cyc = 0, tchg = 0;
  logic blast = 1'b0, bout_prev = 1'b0;
  bit   bout_chk_en = 1'b1;
  bit   finished = 1'b0;

  always #10 clk = ~clk;

  burst_tx_seq u_burst_tx_seq (
    .clk_i(clk), .rst_ni(rst_n), .power_i(power), .burst_i(burst), .txdata_i(txdata),
    .ready_o(ready), .txclk_o(txclk), .bit_valid_o(bit_valid), .bit_o(bit_v),
    .dibit_valid_o(dibit_valid), .dibit_o(dibit), .ramp_up_o(ramp_up),
    .ramp_down_o(ramp_down), .bout_o(bout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // R11 monitor: time each burst_i level change to the bout_o change
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (burst !== blast) begin
      blast <= burst;
      tchg  <= cyc + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && bout_chk_en && bout !== bout_prev)
      chk(cyc - tchg == BD - 1, "R11 bout delay", cyc - tchg, BD - 1);
    bout_prev = bout;
  end

  task automatic power_up(input int raise_at);
    int n;
    tick();
    power = 1'b1;
    n = 0;
    do begin
      tick();
      n++;
      if (n == raise_at) burst = 1'b1;
    end while (!ready && n < 2 * CAL);
    chk(n == CAL + 1, "R2 cal length", n, CAL + 1);
  endtask

  task automatic run_burst(input int stop_b, input bit hold);
    int n, h, l, c_last, total;
    bit b, prev;
    c_last = ((stop_b + 2) / 2) * 2;
    total  = c_last + 2 * FLUSH;
    prev   = 1'b0;
    tick();
    burst = 1'b1;
    tick();
    chk(ready == 1'b0, "R3 ready drop", ready, 0);
    chk(ramp_up == 1'b1, "R10 ramp up", ramp_up, 1);
    n = 1;
    while (!txclk && n < 100) begin tick(); n++; end
    chk(n == SD + 1, "R5 txclk start", n, SD + 1);
    for (int i = 1; i <= 100; i++) begin
      b = 1'($urandom % 2);
      txdata = b;
      if (i == stop_b + 1) burst = 1'b0;
      if (hold && i == total - 1) burst = 1'b1;
      h = 1;
      tick();
      while (txclk && h < 100) begin h++; tick(); end
      chk(h == HALF, "R6 high time", h, HALF);
      chk(bit_valid && bit_v == b, "R7 bit capture", {bit_valid, bit_v}, {1'b1, b});
      if (i % 2 == 0)
        chk(dibit_valid && dibit == {prev, b}, "R8 dibit", {dibit_valid, dibit}, {1'b1, prev, b});
      else
        chk(!dibit_valid, "R8 no dibit on odd bit", dibit_valid, 0);
      if (i == c_last) chk(ramp_down == 1'b1, "R10 ramp down", ramp_down, 1);
      if (ready) begin
        chk(i == total, "R9 flush length", i, total);
        break;
      end
      prev = b;
      l = 1;
      tick();
      while (!txclk && !ready && l < 100) begin l++; tick(); end
      chk(l == HALF, "R6 low time", l, HALF);
    end
    if (hold) begin
      repeat (600) tick();
      chk(ready && !txclk && !ramp_up, "R4 held level no start", {ready, txclk}, 2);
      burst = 1'b0;
      repeat (600) tick();
    end else begin
      repeat (10 + $urandom % 40) tick();
    end
  endtask

  initial begin
    void'($urandom(32'h1b2c));
    rst_n = 1'b0; power = 1'b0; burst = 1'b0; txdata = 1'b0;
    repeat (3) tick();
    chk(!ready && !txclk && !bout && !bit_valid && !dibit_valid && !ramp_up && !ramp_down,
        "R1 reset outputs", {ready, txclk, bout}, 0);
    rst_n = 1'b1;
    repeat (5) tick();
    chk(!ready && !txclk && !bout, "R1 unpowered idle", {ready, txclk, bout}, 0);

    power_up(100);
    repeat (200) tick();
    chk(ready && !txclk, "R4 burst during cal ignored", {ready, txclk}, 2);
    burst = 1'b0;
    repeat (600) tick();

    run_burst(0, 1'b0);
    run_burst(1, 1'b0);
    run_burst(4, 1'b0);
    run_burst(5, 1'b1);
    for (int k = 0; k < 5; k++) run_burst($urandom % 12, 1'b0);

    bout_chk_en = 1'b0;
    tick();
    burst = 1'b1;
    repeat (600) tick();
    power = 1'b0;
    tick();
    chk(!ready && !txclk && !bout, "R12 sleep entry", {ready, txclk, bout}, 0);
    burst = 1'b0;
    repeat (300) tick();
    chk(!ready && !txclk && !bit_valid, "R12 sleep hold", {ready, txclk, bit_valid}, 0);
    power_up(-1);
    bout_chk_en = 1'b1;
    run_burst(3, 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nvec++;
      nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule